// File: doc/BRIEF.md
# Page Access Permission Checker

This block judges one memory access against the result of a finished page-table walk. For every level of the walk it receives the user-allowed, writable, present and reserved-bit-violation flags. It also receives the kind of access (read, write or instruction fetch), whether the requester runs at user or supervisor privilege, and the processor control bits that affect protection. These are write-protect, a guard that forbids supervisor instruction fetches from user pages, address extension, no-execute enable and global-page enable. A flag reports whether the walk already hit a no-execute violation.

One cycle after an access is presented, the block reports three results together with a single-cycle valid pulse. The first is whether the access faults. The second is the page-fault error code the exception path should push. The third is the merged rights that a translation cache entry may store. The walk sequencer drives the inputs. The exception logic and the translation cache consume the outputs.

Top module: `pchk_top`

## Requirements
- R1: While reset is held and after it is released with no access presented, res_valid, res_fault, res_err and res_rights are all zero.
- R2: An access presented with chk_valid high in one cycle produces exactly one res_valid pulse one clock later. res_valid is low after any cycle with chk_valid low, and in that case res_fault, res_err and res_rights keep their previous values.
- R3: On a non-faulting access, res_rights[1] is the AND of pte_user over all levels and res_rights[0] is the AND of pte_write over all levels. On any fault, res_rights is zero.
- R4: On a non-faulting access, res_rights[2] equals ctl_global_en AND leaf_global, where level 0 is the leaf.
- R5: Levels are examined from index LEVELS-1 (top) down to 0 (leaf), and the first level that is not present or has a reserved-bit violation decides the fault. A non-present level gives a fault with res_err[0]=0 and res_err[3]=0. A present level with a reserved-bit violation gives res_err[3]=1 and res_err[0]=1. Levels below the deciding one have no effect.
- R6: acc_kind encodes 0 read, 1 write, 2 fetch; 3 behaves as read. A user access faults unless the merged user bit is set, and a user write also needs the merged writable bit. A supervisor write to a non-writable page faults only when ctl_wp is 1. A supervisor read or fetch never fails this check. Such faults set res_err[0]=1.
- R7: walk_nx_hit high makes any access fault with res_err[0]=1.
- R8: With ctl_sup_exec_guard set, a supervisor fetch whose merged user bit is 1 faults with res_err[0]=1. The same fetch is allowed when the guard is clear, and user fetches are unaffected by the guard.
- R9: On a fault, res_err[2] equals cpl_user and res_err[1] is 1 exactly for a write access. Without a fault, res_err is zero.
- R10: On a faulting fetch, res_err[4] is 1 when ctl_sup_exec_guard is set, or when ctl_addr_ext and ctl_nx_en are both set. Otherwise res_err[4] is 0, and it is always 0 for reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | An access is presented this cycle |
| pte_user | input | LEVELS | User-allowed bit of each level |
| pte_write | input | LEVELS | Writable bit of each level |
| pte_present | input | LEVELS | Present bit of each level |
| pte_rsvd_bad | input | LEVELS | Reserved-bit violation seen at each level |
| leaf_global | input | 1 | Global bit of the leaf entry |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| cpl_user | input | 1 | Requester runs at user privilege |
| ctl_wp | input | 1 | Supervisor write-protect enable |
| ctl_sup_exec_guard | input | 1 | Forbid supervisor fetch from user pages |
| ctl_addr_ext | input | 1 | Extended address translation active |
| ctl_nx_en | input | 1 | No-execute enable |
| walk_nx_hit | input | 1 | Walk flagged a no-execute violation |
| ctl_global_en | input | 1 | Global-page enable |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Access faults |
| res_err | output | 5 | Error code: [0] protection, [1] write, [2] user, [3] reserved, [4] fetch |
| res_rights | output | 3 | {global, user, writable} for the translation cache |

## Verification
The bench builds the checker with LEVELS set to 3, so there is a top, a middle and a leaf level. This puts both directions of the first-failure ordering within reach: a reserved-bit violation above a missing level, and a missing level above a reserved-bit violation. It also covers a single non-user middle level clearing the merged user bit. Directed vectors cover the write-protect, no-execute and supervisor-fetch-guard corners, including the fetch flag on a non-present fault. A deterministic pseudo-random stream then mixes all controls back to back against an independent model.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

    localparam int ERR_W     = 5;
    localparam int ERR_PROT  = 0;
    localparam int ERR_WR    = 1;
    localparam int ERR_USR   = 2;
    localparam int ERR_RSV   = 3;
    localparam int ERR_FETCH = 4;
    localparam int RIGHTS_W  = 3;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    typedef struct packed {
        logic                valid;
        logic                fault;
        logic [ERR_W-1:0]    err;
        logic [RIGHTS_W-1:0] rights;
    } pchk_res_t;

endpackage

// File: rtl/pchk_walk.sv
module pchk_walk #(
    parameter int LEVELS = 4
) (
    input  logic [LEVELS-1:0] pte_user,
    input  logic [LEVELS-1:0] pte_write,
    input  logic [LEVELS-1:0] pte_present,
    input  logic [LEVELS-1:0] pte_rsvd_bad,
    output logic              comb_user,
    output logic              comb_write,
    output logic              walk_np,
    output logic              walk_rsv
);
    logic [LEVELS-1:0] lvl_bad;
    logic [LEVELS-1:0] lvl_rsv;
    logic              hit;

    // per-level classification of a walk failure
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign lvl_bad[g] = !pte_present[g] || pte_rsvd_bad[g];
        assign lvl_rsv[g] = pte_present[g] && pte_rsvd_bad[g];
    end

    // rights start as user+writable and are narrowed by every level
    assign comb_user  = &pte_user;
    assign comb_write = &pte_write;

    // the first failing level, seen from the top, decides the kind
    always_comb begin
        hit      = 1'b0;
        walk_np  = 1'b0;
        walk_rsv = 1'b0;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (!hit && lvl_bad[i]) begin
                hit      = 1'b1;
                walk_rsv = lvl_rsv[i];
                walk_np  = !lvl_rsv[i];
            end
        end
    end

    // R5: a walk failure is either missing or reserved, never both
    always_comb begin
        a_r5_kind_exclusive: assert (!(walk_np && walk_rsv));
    end

endmodule

// File: rtl/pchk_priv.sv
module pchk_priv #(
    parameter int IDX_W = 5
) (
    input  logic wp,
    input  logic is_user,
    input  logic comb_user,
    input  logic comb_write,
    input  logic is_write,
    output logic allowed
);
    localparam int TBL_N = 1 << IDX_W;

    function automatic logic rule(input logic [IDX_W-1:0] ix);
        logic f_wp, f_usr, f_cu, f_cw, f_w;
        f_wp  = ix[4];
        f_usr = ix[3];
        f_cu  = ix[2];
        f_cw  = ix[1];
        f_w   = ix[0];
        if (f_usr) return f_cu && (f_cw || !f_w);
        return !f_w || f_cw || !f_wp;
    endfunction

    logic [TBL_N-1:0]  tbl;
    logic [IDX_W-1:0]  idx;

    for (genvar i = 0; i < TBL_N; i++) begin : g_tbl
        assign tbl[i] = rule(IDX_W'(i));
    end

    assign idx     = {wp, is_user, comb_user, comb_write, is_write};
    assign allowed = tbl[idx];

endmodule

// File: rtl/pchk_err.sv
module pchk_err
    import pchk_pkg::*;
(
    input  logic             fault,
    input  logic             walk_np,
    input  logic             walk_rsv,
    input  logic             is_user,
    input  logic             is_write,
    input  logic             is_exec,
    input  logic             exec_guard,
    input  logic             addr_ext,
    input  logic             nx_en,
    output logic [ERR_W-1:0] err
);
    logic fetch_tag;

    assign fetch_tag = is_exec && (exec_guard || (addr_ext && nx_en));

    always_comb begin
        err = '0;
        if (fault) begin
            err[ERR_PROT]  = !walk_np;
            err[ERR_WR]    = is_write;
            err[ERR_USR]   = is_user;
            err[ERR_RSV]   = walk_rsv;
            err[ERR_FETCH] = fetch_tag;
        end
    end

endmodule

// File: rtl/pchk_top.sv
module pchk_top
    import pchk_pkg::*;
#(
    parameter int LEVELS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chk_valid,
    input  logic [LEVELS-1:0]   pte_user,
    input  logic [LEVELS-1:0]   pte_write,
    input  logic [LEVELS-1:0]   pte_present,
    input  logic [LEVELS-1:0]   pte_rsvd_bad,
    input  logic                leaf_global,
    input  logic [1:0]          acc_kind,
    input  logic                cpl_user,
    input  logic                ctl_wp,
    input  logic                ctl_sup_exec_guard,
    input  logic                ctl_addr_ext,
    input  logic                ctl_nx_en,
    input  logic                walk_nx_hit,
    input  logic                ctl_global_en,
    output logic                res_valid,
    output logic                res_fault,
    output logic [ERR_W-1:0]    res_err,
    output logic [RIGHTS_W-1:0] res_rights
);
    logic comb_user, comb_write, walk_np, walk_rsv, allowed;
    logic is_write, is_exec, guard_hit, fault_now;
    logic [ERR_W-1:0] err_now;
    pchk_res_t res_d, res_q;

    assign is_write = (acc_kind == ACC_WRITE);
    assign is_exec  = (acc_kind == ACC_EXEC);

    pchk_walk #(.LEVELS(LEVELS)) u_walk (
        .pte_user     (pte_user),
        .pte_write    (pte_write),
        .pte_present  (pte_present),
        .pte_rsvd_bad (pte_rsvd_bad),
        .comb_user    (comb_user),
        .comb_write   (comb_write),
        .walk_np      (walk_np),
        .walk_rsv     (walk_rsv)
    );

    pchk_priv u_priv (
        .wp         (ctl_wp),
        .is_user    (cpl_user),
        .comb_user  (comb_user),
        .comb_write (comb_write),
        .is_write   (is_write),
        .allowed    (allowed)
    );

    // supervisor fetch from a user page under the guard
    assign guard_hit = ctl_sup_exec_guard && is_exec && !cpl_user && comb_user;
    assign fault_now = walk_np || walk_rsv || !allowed || walk_nx_hit || guard_hit;

    pchk_err u_err (
        .fault      (fault_now),
        .walk_np    (walk_np),
        .walk_rsv   (walk_rsv),
        .is_user    (cpl_user),
        .is_write   (is_write),
        .is_exec    (is_exec),
        .exec_guard (ctl_sup_exec_guard),
        .addr_ext   (ctl_addr_ext),
        .nx_en      (ctl_nx_en),
        .err        (err_now)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = chk_valid;
        if (chk_valid) begin
            res_d.fault  = fault_now;
            res_d.err    = err_now;
            res_d.rights = fault_now ? '0
                         : {ctl_global_en && leaf_global, comb_user, comb_write};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid  = res_q.valid;
    assign res_fault  = res_q.fault;
    assign res_err    = res_q.err;
    assign res_rights = res_q.rights;

    a_r2_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> res_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !res_valid);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> ($stable(res_fault) && $stable(res_err) && $stable(res_rights)));
    a_r3_no_rights_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> (res_rights == '0));
    a_r9_clean_err: assert property (@(posedge clk) disable iff (!rst_n)
        !res_fault |-> (res_err == '0));
    a_r8_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && ctl_sup_exec_guard && !cpl_user && acc_kind == ACC_EXEC && (&pte_user))
        |=> res_fault);
    a_r10_fetch_only_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && acc_kind != ACC_EXEC) |=> !res_err[ERR_FETCH]);

endmodule

// File: tb/sim_pchk_top.sv
`timescale 1ns/1ps
module sim_pchk_top;
    localparam int L = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chk_valid = 1'b0;
    logic [L-1:0] pu = '0, pw = '0, pp = '0, pr = '0;
    logic lg = 1'b0, usr = 1'b0, wp = 1'b0, gd = 1'b0, ae = 1'b0, nxe = 1'b0, nxh = 1'b0, ge = 1'b0;
    logic [1:0] kind = 2'd0;
    logic res_valid, res_fault;
    logic [4:0] res_err;
    logic [2:0] res_rights;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [8:0] exp_q[$];
    string tag_q[$];
    logic [8:0] last_exp = '0;
    logic [31:0] rng = 32'h1234_5677;

    always #2 clk = ~clk;

    pchk_top #(.LEVELS(L)) u0 (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid),
        .pte_user(pu), .pte_write(pw), .pte_present(pp), .pte_rsvd_bad(pr),
        .leaf_global(lg), .acc_kind(kind), .cpl_user(usr), .ctl_wp(wp),
        .ctl_sup_exec_guard(gd), .ctl_addr_ext(ae), .ctl_nx_en(nxe),
        .walk_nx_hit(nxh), .ctl_global_en(ge),
        .res_valid(res_valid), .res_fault(res_fault), .res_err(res_err),
        .res_rights(res_rights)
    );

    // independent reference: {fault, err[4:0], rights[2:0]}
    function automatic logic [8:0] model(input logic [L-1:0] u, w, p, r, input logic g,
            input logic [1:0] k, input logic us, wpi, gdi, aei, nxei, nxhi, gei);
        logic np = 0, rs = 0, found = 0, cu, cw, deny, gf, f;
        logic [4:0] e = '0;
        logic [2:0] rt = '0;
        for (int lv = L - 1; lv >= 0; lv--) begin
            if (!found && !p[lv]) begin found = 1; np = 1; end
            else if (!found && r[lv]) begin found = 1; rs = 1; end
        end
        cu = 1; cw = 1;
        for (int lv = 0; lv < L; lv++) begin cu = cu & u[lv]; cw = cw & w[lv]; end
        if (us) deny = !cu || (k == 2'd1 && !cw);
        else    deny = (k == 2'd1) && !cw && wpi;
        gf = gdi && !us && (k == 2'd2) && cu;
        f = np || rs || deny || nxhi || gf;
        if (f) begin
            e[0] = !np; e[1] = (k == 2'd1); e[2] = us; e[3] = rs;
            e[4] = (k == 2'd2) && (gdi || (aei && nxei));
        end else begin
            rt = {gei && g, cu, cw};
        end
        return {f, e, rt};
    endfunction

    task automatic apply(input logic [L-1:0] u, w, p, r, input logic g, input logic [1:0] k,
            input logic us, wpi, gdi, aei, nxei, nxhi, gei, input string tag);
        @(negedge clk);
        pu = u; pw = w; pp = p; pr = r; lg = g; kind = k; usr = us; wp = wpi;
        gd = gdi; ae = aei; nxe = nxei; nxh = nxhi; ge = gei; chk_valid = 1'b1;
        last_exp = model(u, w, p, r, g, k, us, wpi, gdi, aei, nxei, nxhi, gei);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        chk_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected result: act %b exp none", {res_fault, res_err, res_rights});
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({res_fault, res_err, res_rights} !== e) begin
                    fails++;
                    $display("FAIL %s: act f=%b err=%b rt=%b exp f=%b err=%b rt=%b", t,
                             res_fault, res_err, res_rights, e[8], e[7:3], e[2:0]);
                end
            end
        end
    end

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 during and after reset
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if ({res_valid, res_fault, res_err, res_rights} !== 10'd0) begin
            fails++;
            $display("FAIL R1 in reset: act %b exp 0", {res_valid, res_fault, res_err, res_rights});
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        checks++;
        if ({res_valid, res_fault, res_err, res_rights} !== 10'd0) begin
            fails++;
            $display("FAIL R1 after reset: act %b exp 0", {res_valid, res_fault, res_err, res_rights});
        end

        // R3 / R4 rights merging
        apply(3'b111, 3'b111, 3'b111, 3'b000, 1, 2'd0, 0, 0, 0, 0, 0, 0, 1, "R4 global set");
        apply(3'b111, 3'b111, 3'b111, 3'b000, 1, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R4 global off");
        apply(3'b101, 3'b111, 3'b111, 3'b000, 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R3 mid level supervisor");
        apply(3'b111, 3'b110, 3'b111, 3'b000, 0, 2'd0, 1, 0, 0, 0, 0, 0, 0, "R3 user read ro");
        // R5 first failing level decides
        apply(3'b111, 3'b111, 3'b011, 3'b001, 0, 2'd1, 0, 0, 0, 0, 0, 0, 0, "R5 top missing");
        apply(3'b111, 3'b111, 3'b111, 3'b010, 0, 2'd0, 1, 0, 0, 0, 0, 0, 0, "R5 mid reserved");
        apply(3'b111, 3'b111, 3'b110, 3'b100, 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R5 reserved above missing");
        apply(3'b000, 3'b000, 3'b101, 3'b001, 0, 2'd1, 1, 1, 0, 0, 0, 0, 0, "R5 missing above reserved");
        // R6 privilege
        apply(3'b011, 3'b111, 3'b111, 3'b000, 0, 2'd0, 1, 0, 0, 0, 0, 0, 0, "R6 user on supervisor page");
        apply(3'b111, 3'b101, 3'b111, 3'b000, 0, 2'd1, 1, 0, 0, 0, 0, 0, 0, "R6 user write ro");
        apply(3'b000, 3'b011, 3'b111, 3'b000, 0, 2'd1, 0, 0, 0, 0, 0, 0, 0, "R6 sup write ro wp off");
        apply(3'b000, 3'b011, 3'b111, 3'b000, 0, 2'd1, 0, 1, 0, 0, 0, 0, 0, "R6 sup write ro wp on");
        apply(3'b111, 3'b111, 3'b111, 3'b000, 0, 2'd3, 1, 0, 0, 0, 0, 0, 0, "R6 kind 3 as read");
        // R7 no-execute
        apply(3'b111, 3'b111, 3'b111, 3'b000, 0, 2'd0, 1, 0, 0, 0, 0, 1, 0, "R7 nx on read");
        // R8 supervisor fetch guard
        apply(3'b111, 3'b111, 3'b111, 3'b000, 0, 2'd2, 0, 0, 1, 0, 0, 0, 0, "R8 guard hit");
        apply(3'b111, 3'b111, 3'b111, 3'b000, 0, 2'd2, 0, 0, 0, 0, 0, 0, 0, "R8 guard off");
        apply(3'b111, 3'b111, 3'b111, 3'b000, 0, 2'd2, 1, 0, 1, 0, 0, 0, 0, "R8 user fetch");
        apply(3'b110, 3'b111, 3'b111, 3'b000, 0, 2'd2, 0, 0, 1, 0, 0, 0, 0, "R8 supervisor page");
        // R9 / R10 error code bits
        apply(3'b111, 3'b111, 3'b111, 3'b000, 0, 2'd2, 1, 0, 0, 1, 1, 1, 0, "R10 ext+nx fetch");
        apply(3'b111, 3'b111, 3'b111, 3'b000, 0, 2'd2, 1, 0, 0, 1, 0, 1, 0, "R10 ext only fetch");
        apply(3'b111, 3'b111, 3'b011, 3'b000, 0, 2'd2, 0, 0, 1, 0, 0, 0, 0, "R10 missing fetch");
        apply(3'b111, 3'b111, 3'b111, 3'b000, 0, 2'd1, 1, 0, 1, 1, 1, 1, 0, "R9 user write nx");

        // R2 hold: inputs change with chk_valid low
        idle();
        pu = '0; pp = '0; usr = 1; nxh = 1;
        repeat (2) @(negedge clk);
        #1;
        checks++;
        if (res_valid !== 1'b0 || {res_fault, res_err, res_rights} !== last_exp) begin
            fails++;
            $display("FAIL R2 hold: act v=%b %b exp v=0 %b", res_valid,
                     {res_fault, res_err, res_rights}, last_exp);
        end

        // mixed stream, back to back
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            a = rng;
            apply(a[2:0] | 3'(a[20]), a[5:3] | 3'(a[21]),
                  (a[22] ? a[8:6] : 3'b111), (a[23] ? a[11:9] : 3'b000),
                  a[12], 2'(a[14:13] % 2'd3), a[15], a[16], a[17], a[18], a[19],
                  a[24] & a[25], a[26], "R6 R8 R9 R10 mixed");
        end
        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing results: act %0d pending exp 0", exp_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule